// File: doc/BRIEF.md
# Programmable Output Macrocell Bank

This block is the output stage of a sum-of-products logic array. It has ten cells. Each cell takes the AND product terms assigned to it from a wide input vector and ORs them into a sum. A per-cell mode bit chooses whether the cell presents that sum directly or a registered copy of it. A per-cell polarity bit can invert the value on its way to the output. Each cell also has its own output-enable term, and a feedback value that is routed back into the array.

All ten registers share one synchronous preset term and one asynchronous reset term. A test preload mode forces the register contents from per-cell data on a clock edge, and the polarity bit does not affect that data. When the power-on reset input is asserted, every register is cleared. After it is released, a hold counter makes the block ignore a fixed number of clock edges before registers start to update.

Top module: `pld_cell_bank`

## Requirements
- R1: Cells 0 to 9 OR together the first 8, 10, 12, 14, 16, 16, 14, 12, 10 and 8 bits of their own 16-bit slice of `pt_in`. Cell i's slice is `pt_in[16*i +: 16]`. Bits beyond a cell's count have no effect.
- R2: When `reg_mode[i]`=1, cell i presents its register. When it is 0, the cell presents its combinational sum. `q_out[i]` is the presented value XOR `inv_out[i]`, so a 1 in `inv_out[i]` inverts the output.
- R3: `areset_pt`=1 clears all ten registers at once, without waiting for a clock edge. It overrides preset, preload and capture, including when preset is active in the same cycle.
- R4: On an effective clock edge with `preset_pt`=1, no reset and no preload, all ten registers become 1.
- R5: On an effective clock edge with `preload_en`=1 and no reset, each register takes `preload_d[i]`, whatever the value of `inv_out[i]`. Preload overrides both preset and normal capture.
- R6: While `por_n`=0, all registers are 0, and a registered cell's `q_out[i]` equals `inv_out[i]`. After `por_n` rises, the first HOLD_CYCLES (8) rising edges leave the registers unchanged.
- R7: `q_oe[i]` follows `oe_pt[i]`. When the output is enabled, `fb[i]` carries the presented (uninverted) value. When it is disabled, `fb[i]` carries `pin_in[i]`.
- R8: On an effective clock edge with no reset, preload or preset, each register captures its cell's sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low |
| pt_in | input | 160 | Product-term values, 16 per cell |
| oe_pt | input | 10 | Output-enable term for each cell |
| reg_mode | input | 10 | 1 selects registered output, 0 selects combinational |
| inv_out | input | 10 | 1 inverts the output |
| preset_pt | input | 1 | Shared synchronous preset term |
| areset_pt | input | 1 | Shared asynchronous reset term |
| preload_en | input | 1 | Test preload mode |
| preload_d | input | 10 | Per-cell preload level |
| pin_in | input | 10 | Pin level fed back when the output is disabled |
| q_out | output | 10 | Cell outputs after polarity |
| q_oe | output | 10 | Output enables |
| fb | output | 10 | Feedback values into the array |

## Verification
On every clock the assertions check four things. Reset leaves the register state at zero. Preset, preload and capture each load the value they select. The register holds while the post-reset hold window is open, and the window never reopens without a new reset. The bench scenarios cover the rest. These are the per-cell product-term boundaries, polarity inversion after power-on, the choice of feedback source, and preset colliding with reset. They also cover preload under both polarity settings, which only shows at the ports, through the registered outputs and the feedback.

// File: rtl/pld_cell_bank.sv
module pld_cell_bank #(
  parameter int NCELL       = 10,
  parameter int PT_MIN      = 8,
  parameter int PT_MAX      = 16,
  parameter int HOLD_CYCLES = 8
) (
  input  logic                    clk,
  input  logic                    por_n,
  input  logic [NCELL*PT_MAX-1:0] pt_in,
  input  logic [NCELL-1:0]        oe_pt,
  input  logic [NCELL-1:0]        reg_mode,
  input  logic [NCELL-1:0]        inv_out,
  input  logic                    preset_pt,
  input  logic                    areset_pt,
  input  logic                    preload_en,
  input  logic [NCELL-1:0]        preload_d,
  input  logic [NCELL-1:0]        pin_in,
  output logic [NCELL-1:0]        q_out,
  output logic [NCELL-1:0]        q_oe,
  output logic [NCELL-1:0]        fb
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);

  logic [NCELL-1:0] sum, r, val;
  logic [CW-1:0]    hold_cnt;
  logic             ready, arst;

  for (genvar g = 0; g < NCELL; g++) begin : g_cell
    localparam int M   = (g < NCELL - 1 - g) ? g : NCELL - 1 - g;
    localparam int CNT = (PT_MIN + 2 * M > PT_MAX) ? PT_MAX : PT_MIN + 2 * M;
    assign sum[g] = |pt_in[g*PT_MAX +: CNT];
  end

  assign ready = (hold_cnt == CW'(HOLD_CYCLES));
  assign arst  = !por_n || areset_pt;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n)      hold_cnt <= '0;
    else if (!ready) hold_cnt <= hold_cnt + 1'b1;

  always_ff @(posedge clk or posedge arst)
    if (arst)            r <= '0;
    else if (ready) begin
      if (preload_en)     r <= preload_d;
      else if (preset_pt) r <= '1;
      else                r <= sum;
    end

  assign val   = (reg_mode & r) | (~reg_mode & sum);
  assign q_out = val ^ inv_out;
  assign q_oe  = oe_pt;
  assign fb    = (oe_pt & val) | (~oe_pt & pin_in);
endmodule

module pld_cell_bank_chk #(
  parameter int NCELL = 10
) (
  input logic             clk,
  input logic             por_n,
  input logic             areset_pt,
  input logic             preset_pt,
  input logic             preload_en,
  input logic [NCELL-1:0] preload_d,
  input logic             ready,
  input logic [NCELL-1:0] sum,
  input logic [NCELL-1:0] r
);
  assert_areset_clears_R3: assert property (@(posedge clk) disable iff (!por_n)
    areset_pt |-> (r == '0));

  assert_preset_sets_R4: assert property (@(posedge clk) disable iff (!por_n)
    (ready && !areset_pt && !preload_en && preset_pt) |=> (areset_pt || r == '1));

  assert_preload_loads_R5: assert property (@(posedge clk) disable iff (!por_n)
    (ready && !areset_pt && preload_en) |=> (areset_pt || r == $past(preload_d)));

  assert_hold_window_R6: assert property (@(posedge clk) disable iff (!por_n)
    (!ready && !areset_pt) |=> (areset_pt || $stable(r)));

  assert_ready_sticky_R6: assert property (@(posedge clk) disable iff (!por_n)
    ready |=> ready);

  assert_capture_R8: assert property (@(posedge clk) disable iff (!por_n)
    (ready && !areset_pt && !preload_en && !preset_pt) |=> (areset_pt || r == $past(sum)));
endmodule

bind pld_cell_bank pld_cell_bank_chk #(.NCELL(NCELL)) u_chk (
  .clk(clk), .por_n(por_n), .areset_pt(areset_pt), .preset_pt(preset_pt),
  .preload_en(preload_en), .preload_d(preload_d), .ready(ready), .sum(sum), .r(r)
);

// File: tb/pld_cell_bank_tb.sv
`timescale 1ns/1ps
module pld_cell_bank_tb;
  localparam int N = 10, P = 16, H = 8;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         por_n, preset, ar, pl;
  logic [N*P-1:0] pt;
  logic [N-1:0] oe, mode, inv, pd, pin, q_out, q_oe, fb;
  logic [N-1:0] m;
  int rc, n_chk = 0, n_fail = 0;
  int cnt_tab[N] = '{8, 10, 12, 14, 16, 16, 14, 12, 10, 8};

  pld_cell_bank #(.NCELL(N), .PT_MIN(8), .PT_MAX(P), .HOLD_CYCLES(H)) u_dut (
    .clk(clk), .por_n(por_n), .pt_in(pt), .oe_pt(oe), .reg_mode(mode), .inv_out(inv),
    .preset_pt(preset), .areset_pt(ar), .preload_en(pl), .preload_d(pd), .pin_in(pin),
    .q_out(q_out), .q_oe(q_oe), .fb(fb));

  function automatic logic [N-1:0] f_sum(logic [N*P-1:0] v);
    logic [N-1:0] s = '0;
    for (int i = 0; i < N; i++)
      for (int k = 0; k < cnt_tab[i]; k++)
        if (v[i*P+k]) s[i] = 1'b1;
    return s;
  endfunction

  task automatic chk(string tag, logic [N-1:0] got, logic [N-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %b exp %b", tag, got, exp);
    end
  endtask

  task automatic check_all(string tag);
    logic [N-1:0] v;
    v = (mode & m) | (~mode & f_sum(pt));
    chk({tag, " q_out"}, q_out, v ^ inv);
    chk({tag, " R7 q_oe"}, q_oe, oe);
    chk({tag, " R7 fb"}, fb, (oe & v) | (~oe & pin));
  endtask

  task automatic tick();
    @(posedge clk);
    if (por_n) begin
      if (rc < H) rc++;
      else if (!ar) begin
        if (pl) m = pd;
        else if (preset) m = '1;
        else m = f_sum(pt);
      end
    end
    @(negedge clk);
  endtask

  task automatic set_ar(logic v);
    ar = v;
    if (v) m = '0;
    #1;
  endtask

  task automatic rand_pt();
    for (int w = 0; w < N*P/32; w++) pt[w*32 +: 32] = $urandom;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    void'($urandom(32'd4711));
    por_n = 0; preset = 0; ar = 0; pl = 0; pt = '0; oe = '1; mode = '1;
    inv = 10'b1011001010; pd = '0; pin = '0; m = '0; rc = 0;
    #12;
    check_all("R6 reset state");
    @(negedge clk);
    por_n = 1; pt = '1;
    for (int i = 0; i < H; i++) begin
      tick();
      check_all("R6 hold window");
    end
    chk("R6 still low", q_out, inv);
    tick();
    check_all("R8 first capture");
    chk("R8 all ones", q_out, ~inv);

    pt = '0; pt[8] = 1'b1; mode = '0; inv = '0; #1;
    chk("R1 cell0 bit8 ignored", q_out, 10'b0);
    pt[7] = 1'b1; #1;
    chk("R1 cell0 bit7 used", q_out, 10'b0000000001);
    pt = '0; pt[4*P+15] = 1'b1; pt[9*P+8] = 1'b1; #1;
    chk("R1 cell4 bit15 used cell9 bit8 ignored", q_out, 10'b0000010000);
    inv = '1; #1;
    chk("R2 comb inversion", q_out, 10'b1111101111);

    mode = '1; inv = '0; pt = '1; preset = 1; set_ar(1);
    check_all("R3 async clear");
    tick();
    check_all("R3 preset with reset");
    chk("R3 regs zero", q_out, 10'b0);
    set_ar(0); pt = '0;
    tick();
    check_all("R4 preset");
    chk("R4 regs ones", q_out, '1);
    preset = 0;

    pl = 1; preset = 1; pd = 10'b1010011100; inv = '0;
    tick();
    check_all("R5 preload inv0");
    chk("R5 value inv0", q_out, 10'b1010011100);
    inv = '1; pd = 10'b0101100110;
    tick();
    check_all("R5 preload inv1");
    chk("R5 fb inv1", fb, 10'b0101100110);
    pl = 0; preset = 0;

    oe = 10'b0000011111; pin = 10'b1100110011; #1;
    check_all("R7 feedback from pin");

    for (int it = 0; it < 400; it++) begin
      rand_pt();
      mode = N'($urandom); inv = N'($urandom); oe = N'($urandom);
      pin = N'($urandom); pd = N'($urandom);
      preset = ($urandom % 8 == 0);
      pl = ($urandom % 8 == 1);
      set_ar($urandom % 16 == 0);
      check_all("R2 random comb");
      tick();
      check_all("R8 random");
    end

    set_ar(0); pl = 0; preset = 0; mode = '1; inv = 10'b0110100101;
    por_n = 0; m = '0; rc = 0; #1;
    chk("R6 output inversion after reset", q_out, inv);
    check_all("R6 second reset");
    report();
  end
endmodule